// File: doc/BRIEF.md
# Triangular Carrier PWM Modulator

This block turns a 16-bit duty value into one center-aligned pulse train. It builds its triangle from a timer that is shared across the chip. The timer arrives as a period, a running count, a prescaler value and a one-cycle enable. The block never counts time by itself, so its switching edges stay aligned with every other consumer of that timer. The carrier climbs by one on each enabled cycle during the first half of the timer span. It falls by one during the second half and never drops below zero. It is forced to zero whenever the count reads zero.

The requested duty sits in a shadow input, and the compare stage only sees it after it has been copied into an active register. In single-rate mode the copy happens at the carrier minimum, which is the enabled cycle with count zero. In double-rate mode a copy also happens at the carrier peak, which is the enabled cycle whose count equals half the period minus one. The output is high while twice the carrier is below the active duty. The carrier value is exported for observation.

Top module: `tri_carrier_pwm`

## Requirements
- R1: While reset is asserted, `carrierOut` is 0 and `pwmOut` is 0; the active duty is cleared to 0.
- R2: On an enabled cycle with `tmrCount` equal to 0, the carrier becomes 0 after that clock edge.
- R3: On an enabled cycle with `tmrCount` nonzero and below floor(`tmrPeriod`/2) minus 1, the carrier rises by exactly 1 after the edge.
- R4: On an enabled cycle with `tmrCount` nonzero and at or above floor(`tmrPeriod`/2) minus 1, the carrier falls by 1 after the edge, and stays at 0 instead of wrapping when it is already 0.
- R5: When `tmrPrescale` is 2 or more and `tmrTick` is low, neither the carrier nor the active duty changes.
- R6: When `tmrPrescale` is 0 or 1, every cycle counts as enabled, whatever the level of `tmrTick`.
- R7: On an enabled cycle with `tmrCount` equal to 0, `nextDuty` is copied into the active duty, and the new value takes effect right after that edge, together with the carrier reset.
- R8: With `dblRate` at 1, `nextDuty` is also copied on the enabled cycle where `tmrCount` equals floor(`tmrPeriod`/2) minus 1; with `dblRate` at 0 no copy happens there.
- R9: A change of `nextDuty` on any other cycle has no effect on `pwmOut` until the next copy point.
- R10: `pwmOut` is 1 exactly when 2×`carrierOut` is less than the active duty, and it updates in the same cycle as `carrierOut`. An active duty of 0 therefore gives a constant 0, and an active duty at or above the period gives a constant 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock (one tick every 4 ns at 250 MHz) |
| rstN | input | 1 | Asynchronous reset, active low |
| tmrPeriod | input | 16 | Timer span in ticks |
| tmrCount | input | 16 | Timer count, runs from 0 to period-1 |
| tmrPrescale | input | 16 | Prescaler ratio of the timer |
| tmrTick | input | 1 | High on cycles where the timer advanced |
| nextDuty | input | 16 | Requested duty in period ticks (shadow value) |
| dblRate | input | 1 | 0: copy at minimum only; 1: copy at minimum and peak |
| pwmOut | output | 1 | Modulated output |
| carrierOut | output | 16 | Current carrier value |

## Verification
The carrier reset and the duty copy take place on the same enabled cycle at count zero. In double-rate mode, the duty copy also falls on the cycle where the carrier turns from rising to falling. The bench changes `nextDuty` on exactly the cycle that presents count zero. It then checks that the first output sample after that edge already compares a zero carrier against the new duty. A separate run switches `nextDuty` a few counts before the peak and expects the new pulse width to appear only from the turn cycle onward.

// File: rtl/tcpwm_pkg.sv
`timescale 1ns/1ps
package tcpwm_pkg;
  // Strobes sent from control to datapath each cycle
  typedef struct packed {
    logic clear;   // force carrier to zero
    logic up;      // carrier + 1
    logic down;    // carrier - 1, floored at zero
    logic load;    // copy shadow duty into active duty
  } tcpwm_strobe_t;
endpackage

// File: rtl/tcpwm_ctrl.sv
`timescale 1ns/1ps
module tcpwm_ctrl
  import tcpwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0]  tmrPeriod,
  input  logic [W-1:0]  tmrCount,
  input  logic [W-1:0]  tmrPrescale,
  input  logic          tmrTick,
  input  logic          dblRate,
  output tcpwm_strobe_t strobes
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] halfPeriod;
  logic [W-1:0] turnPoint;
  logic         stepEn;
  logic         atZero;
  logic         atTurn;
  logic         rising;

  always_comb begin
    halfPeriod = tmrPeriod >> 1;
    turnPoint  = halfPeriod - ONE;
    // prescale of 0 or 1 means the timer advances every cycle
    stepEn     = tmrTick | (tmrPrescale <= ONE);
    atZero     = (tmrCount == '0);
    atTurn     = (tmrCount == turnPoint);
    rising     = (tmrCount < turnPoint);
  end

  always_comb begin
    strobes       = '0;
    strobes.clear = stepEn & atZero;
    strobes.up    = stepEn & ~atZero & rising;
    strobes.down  = stepEn & ~atZero & ~rising;
    strobes.load  = stepEn & (atZero | (dblRate & atTurn));
  end
endmodule

// File: rtl/tcpwm_datapath.sv
`timescale 1ns/1ps
module tcpwm_datapath
  import tcpwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  tcpwm_strobe_t strobes,
  input  logic [W-1:0]  nextDuty,
  output logic [W-1:0]  carrier,
  output logic [W-1:0]  activeDuty,
  output logic          pwmOut
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W:0] twiceCarrier;
  logic [W:0] dutyWide;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      carrier <= '0;
    end else if (strobes.clear) begin
      carrier <= '0;
    end else if (strobes.up) begin
      carrier <= carrier + ONE;
    end else if (strobes.down && carrier != '0) begin
      carrier <= carrier - ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeDuty <= '0;
    end else if (strobes.load) begin
      activeDuty <= nextDuty;
    end
  end

  always_comb begin
    twiceCarrier = {carrier, 1'b0};
    dutyWide     = {1'b0, activeDuty};
    pwmOut       = (twiceCarrier < dutyWide);
  end
endmodule

// File: rtl/tri_carrier_pwm.sv
`timescale 1ns/1ps
module tri_carrier_pwm
  import tcpwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] tmrPeriod,
  input  logic [W-1:0] tmrCount,
  input  logic [W-1:0] tmrPrescale,
  input  logic         tmrTick,
  input  logic [W-1:0] nextDuty,
  input  logic         dblRate,
  output logic         pwmOut,
  output logic [W-1:0] carrierOut
);
  tcpwm_strobe_t strobes;
  logic [W-1:0]  activeDuty;

  tcpwm_ctrl #(.W(W)) u_ctrl (
    .tmrPeriod   (tmrPeriod),
    .tmrCount    (tmrCount),
    .tmrPrescale (tmrPrescale),
    .tmrTick     (tmrTick),
    .dblRate     (dblRate),
    .strobes     (strobes)
  );

  tcpwm_datapath #(.W(W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .nextDuty   (nextDuty),
    .carrier    (carrierOut),
    .activeDuty (activeDuty),
    .pwmOut     (pwmOut)
  );
endmodule

// File: rtl/tri_carrier_pwm_chk.sv
`timescale 1ns/1ps
module tri_carrier_pwm_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic [W-1:0] tmrPeriod,
  input logic [W-1:0] tmrCount,
  input logic [W-1:0] tmrPrescale,
  input logic         tmrTick,
  input logic [W-1:0] nextDuty,
  input logic         dblRate,
  input logic         pwmOut,
  input logic [W-1:0] carrierOut,
  input logic [W-1:0] activeDuty
);
  logic [W-1:0] turnC;
  logic         enC;
  always_comb begin
    turnC = (tmrPeriod >> 1) - W'(1);
    enC   = tmrTick || (tmrPrescale <= W'(1));
  end

  p_reset_r1: assert property (@(posedge clk)
    !rstN |-> (carrierOut == '0 && !pwmOut));

  p_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    (enC && tmrCount == '0) |=> carrierOut == '0);

  p_rise_r3: assert property (@(posedge clk) disable iff (!rstN)
    (enC && tmrCount != '0 && tmrCount < turnC) |=> carrierOut == $past(carrierOut) + W'(1));

  p_fall_r4: assert property (@(posedge clk) disable iff (!rstN)
    (enC && tmrCount != '0 && tmrCount >= turnC && carrierOut != '0)
      |=> carrierOut == $past(carrierOut) - W'(1));

  p_floor_r4: assert property (@(posedge clk) disable iff (!rstN)
    (enC && tmrCount != '0 && tmrCount >= turnC && carrierOut == '0) |=> carrierOut == '0);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !enC |=> ($stable(carrierOut) && $stable(activeDuty)));

  p_load_min_r7: assert property (@(posedge clk) disable iff (!rstN)
    (enC && tmrCount == '0) |=> activeDuty == $past(nextDuty));

  p_load_peak_r8: assert property (@(posedge clk) disable iff (!rstN)
    (enC && dblRate && tmrCount != '0 && tmrCount == turnC) |=> activeDuty == $past(nextDuty));

  p_keep_r9: assert property (@(posedge clk) disable iff (!rstN)
    (enC && tmrCount != '0 && !(dblRate && tmrCount == turnC)) |=> $stable(activeDuty));

  p_zero_low_r10: assert property (@(posedge clk) disable iff (!rstN)
    (activeDuty == '0) |-> !pwmOut);
endmodule

bind tri_carrier_pwm tri_carrier_pwm_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .tmrPeriod   (tmrPeriod),
  .tmrCount    (tmrCount),
  .tmrPrescale (tmrPrescale),
  .tmrTick     (tmrTick),
  .nextDuty    (nextDuty),
  .dblRate     (dblRate),
  .pwmOut      (pwmOut),
  .carrierOut  (carrierOut),
  .activeDuty  (activeDuty)
);

// File: tb/tri_carrier_pwm_bench.sv
`timescale 1ns/1ps
module tri_carrier_pwm_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] tmrPeriod = '0;
  logic [15:0] tmrCount = '0;
  logic [15:0] tmrPrescale = '0;
  logic        tmrTick = 1'b0;
  logic [15:0] nextDuty = '0;
  logic        dblRate = 1'b0;
  logic        pwmOut;
  logic [15:0] carrierOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [15:0] car;
    logic        pwm;
    string       req;
  } exp_t;
  exp_t q[$];

  logic [15:0] mCar = '0;
  logic [15:0] mDuty = '0;

  always #5 clk = ~clk;

  tri_carrier_pwm u_tri_carrier_pwm (
    .clk(clk), .rstN(rstN), .tmrPeriod(tmrPeriod), .tmrCount(tmrCount),
    .tmrPrescale(tmrPrescale), .tmrTick(tmrTick), .nextDuty(nextDuty),
    .dblRate(dblRate), .pwmOut(pwmOut), .carrierOut(carrierOut)
  );

  // driver: one cycle of stimulus plus the expected result after its edge
  task automatic drive1(input logic tick, input logic [15:0] cnt, input logic [15:0] per,
                        input logic [15:0] presc, input logic [15:0] nd, input logic dbl);
    logic        en;
    logic [15:0] turn;
    string       tag;
    exp_t        item;
    @(negedge clk);
    tmrTick = tick; tmrCount = cnt; tmrPeriod = per;
    tmrPrescale = presc; nextDuty = nd; dblRate = dbl;
    en   = tick || (presc <= 16'd1);
    turn = (per >> 1) - 16'd1;
    tag  = "R5";
    if (en) begin
      if (cnt == 16'd0) begin mCar = '0; tag = "R2"; end
      else if (cnt < turn) begin mCar = mCar + 16'd1; tag = "R3"; end
      else begin if (mCar != '0) mCar = mCar - 16'd1; tag = "R4"; end
      if (cnt == 16'd0) begin mDuty = nd; tag = "R7"; end
      else if (dbl && cnt == turn) begin mDuty = nd; tag = "R8"; end
      else if (nd != mDuty) tag = "R9";
      if (!tick) tag = "R6";
    end
    if (mDuty == 16'd0 || mDuty >= per) tag = "R10";
    item.car = mCar;
    item.pwm = ((2 * int'(mCar)) < int'(mDuty));
    item.req = tag;
    q.push_back(item);
  endtask

  // one timer span; nextDuty is dutyA before count swapAt, dutyB from it on
  task automatic runPeriod(input int per, input int presc, input logic dbl,
                           input int dutyA, input int swapAt, input int dutyB,
                           input logic tickLvl);
    for (int c = 0; c < per; c++) begin
      logic [15:0] nd;
      nd = (c < swapAt) ? 16'(dutyA) : 16'(dutyB);
      drive1(tickLvl, 16'(c), 16'(per), 16'(presc), nd, dbl);
      for (int k = 1; k < presc; k++)
        drive1(1'b0, 16'(c), 16'(per), 16'(presc), nd, dbl);
    end
  endtask

  // monitor: compares each result shortly after the edge that produced it
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (carrierOut !== e.car || pwmOut !== e.pwm) begin
          errors++;
          $display("FAIL %s: carrier=%0d pwm=%0b, expected carrier=%0d pwm=%0b",
                   e.req, carrierOut, pwmOut, e.car, e.pwm);
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run state=hung, expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;  // R1 reset state
    if (carrierOut !== 16'd0 || pwmOut !== 1'b0) begin
      errors++;
      $display("FAIL R1: carrier=%0d pwm=%0b, expected carrier=0 pwm=0", carrierOut, pwmOut);
    end
    rstN = 1'b1;

    // R2 R3 R4 R5: prescaled timer, steady duty
    runPeriod(20, 3, 1'b0, 10, 20, 10, 1'b1);
    runPeriod(20, 3, 1'b0, 10, 20, 10, 1'b1);
    // R9: change mid-span in single rate is ignored until next minimum
    runPeriod(20, 2, 1'b0, 6, 7, 14, 1'b1);
    runPeriod(20, 2, 1'b0, 14, 20, 14, 1'b1);
    // R8: double rate, change before the peak is taken at the peak
    runPeriod(20, 2, 1'b1, 4, 5, 12, 1'b1);
    // R7: change presented in the very cycle of count zero
    runPeriod(20, 2, 1'b1, 7, 0, 15, 1'b1);
    // R10: duty 0 constant low, duty at/above period constant high
    runPeriod(24, 1, 1'b0, 0, 24, 0, 1'b1);
    runPeriod(24, 1, 1'b0, 30, 24, 30, 1'b1);
    runPeriod(24, 1, 1'b0, 24, 24, 24, 1'b1);
    // R6: prescale 0 with the enable held low still steps every cycle
    runPeriod(16, 0, 1'b0, 8, 16, 8, 1'b0);
    runPeriod(17, 0, 1'b1, 5, 3, 11, 1'b0);

    while (q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule